// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Loader

This block receives configuration words over a three-wire serial port (serial data, serial clock, load strobe) and routes each word's payload into one of several parallel holding registers. The three serial pins and a chip-enable pin are brought into the system clock domain through multi-flop synchronizers. Each rising serial-clock edge shifts one data bit into a 21-bit shift register, most significant bit first. When the load strobe rises, the two bits shifted in last act as an address. The 19 bits above them are copied into the addressed holding register.

The holding registers drive the block's outputs in parallel. Other logic (dividers, charge-pump control and so on) consumes them. A one-cycle update pulse and the index of the register just written let that logic react to a new setting. A power-down output combines the synchronized chip-enable pin with one bit of holding register 1. Chip enable low always forces power-down.

Sequencing of the load strobe is held by a two-state machine. In state `LD_ARMED` the strobe is seen low. The transition `ARMED_TO_HELD` fires when the synchronized strobe is seen high, and that transition is the only moment a register write happens. In state `LD_HELD` further serial clocks keep shifting but load nothing. The transition `HELD_TO_ARMED` occurs when the strobe falls.

Top module: `cfg_word_loader`

## Requirements
- R1: During and after reset every holding register reads zero, the update pulse is low, and the power-down output is 1 (chip enable has not yet been seen high).
- R2: Each rising edge of the serial clock shifts the serial data bit into bit 0 of the shift register while older bits move up by one. Words are sent MSB first, so the first of 21 bits lands in payload bit 18 and the final two bits form the address (second-to-last bit = address bit 1).
- R3: On a load-strobe rising edge, address 00 writes holding register 0, 01 writes register 1 and 10 writes register 2, each with the 19 payload bits (shift register bits 20:2).
- R4: Address 11 is reserved. A load with that address changes no holding register and produces no update pulse.
- R5: A holding register changes only when a load addresses it. All other registers keep their values.
- R6: Only the rising edge of the load strobe loads. Keeping it high while more words are clocked in, or letting it fall, writes nothing, and the next rising edge loads the newest 21 bits.
- R7: When a load-strobe rise and a serial-clock rise are seen in the same system cycle, the load uses the shift register contents from before that clock's shift.
- R8: Each register write produces a one-cycle update pulse whose index output names the written register. During that cycle the register already shows its new value.
- R9: The power-down output equals NOT(synchronized chip enable) OR bit 0 of holding register 1.
- R10: If more than 21 bits are clocked in before a load, only the last 21 bits count and older bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk_i | input | 1 | Serial clock pin (asynchronous) |
| ser_data_i | input | 1 | Serial data pin (asynchronous) |
| ser_load_i | input | 1 | Load strobe pin (asynchronous) |
| chip_en_i | input | 1 | Chip-enable pin (asynchronous), low forces power-down |
| latches_o | output | NUM_LATCH*PAYLOAD_W (57) | Holding registers, register k at bits [19k+18:19k] |
| pwr_down_o | output | 1 | Power-down status |
| load_pulse_o | output | 1 | One-cycle update pulse |
| load_idx_o | output | ADDR_W (2) | Index of the register just written |

## Verification
The serial-clock shift and the load-strobe transfer can fall in the same system cycle, because both pins pass through identically deep synchronizers. The bench provokes this by raising both pins in the same time step on the final bit of a word, so the word before that bit carries a valid address and the word after it generally carries a different one. A bench model applies the load first and the shift second, and the contents of every holding register, the count of update pulses and the last pulse index are compared with that model. Random words, including reserved addresses, over-length words and chip-enable toggles, cover the remaining behaviour.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
    typedef enum logic {
        LD_ARMED = 1'b0,
        LD_HELD  = 1'b1
    } ld_state_e;
endpackage

// File: rtl/cwl_sync.sv
module cwl_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cwl_shifter.sv
module cwl_shifter #(
    parameter int WORD_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s_i,
    input  logic              data_s_i,
    output logic              shift_o,
    output logic [WORD_W-1:0] word_o
);
    logic sclk_q;

    assign shift_o = sclk_s_i & ~sclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            word_o <= '0;
        end else begin
            sclk_q <= sclk_s_i;
            if (shift_o) begin
                word_o <= {word_o[WORD_W-2:0], data_s_i};
            end
        end
    end

    // R2: one new bit enters at the bottom, older bits move up
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o |=> (word_o[0] == $past(data_s_i)) &&
                    (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));
endmodule

// File: rtl/cwl_load_fsm.sv
module cwl_load_fsm
    import cwl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic le_s_i,
    output logic fire_o
);
    ld_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LD_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        fire_o  = 1'b0;
        unique case (state_q)
            LD_ARMED: begin
                if (le_s_i) begin
                    state_d = LD_HELD;   // ARMED_TO_HELD
                    fire_o  = 1'b1;
                end
            end
            LD_HELD: begin
                if (!le_s_i) begin
                    state_d = LD_ARMED;  // HELD_TO_ARMED
                end
            end
            default: state_d = LD_ARMED;
        endcase
    end

    // R6: a strobe that stays high never fires twice in a row
    assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);
endmodule

// File: rtl/cwl_latch_bank.sv
module cwl_latch_bank #(
    parameter int PAYLOAD_W = 19,
    parameter int ADDR_W    = 2,
    parameter int NUM_LATCH = 3,
    localparam int WORD_W   = PAYLOAD_W + ADDR_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                fire_i,
    input  logic [WORD_W-1:0]                   word_i,
    output logic [NUM_LATCH-1:0][PAYLOAD_W-1:0] latches_o,
    output logic                                pulse_o,
    output logic [ADDR_W-1:0]                   idx_o
);
    logic [ADDR_W-1:0]    addr;
    logic [PAYLOAD_W-1:0] payload;
    logic                 hit;

    assign addr    = word_i[ADDR_W-1:0];
    assign payload = word_i[WORD_W-1:ADDR_W];
    assign hit     = fire_i && (int'(addr) < NUM_LATCH);

    for (genvar g = 0; g < NUM_LATCH; g++) begin : g_latch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latches_o[g] <= '0;
            end else if (fire_i && (addr == ADDR_W'(g))) begin
                latches_o[g] <= payload;
            end
        end

        // R5: unaddressed registers hold their value
        assert_hold_unaddressed_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(fire_i && (addr == ADDR_W'(g))) |=> $stable(latches_o[g]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o <= 1'b0;
            idx_o   <= '0;
        end else begin
            pulse_o <= hit;
            if (hit) begin
                idx_o <= addr;
            end
        end
    end

    // R4: a reserved address writes nothing and raises no pulse
    assert_reserved_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && (int'(addr) >= NUM_LATCH)) |=> ($stable(latches_o) && !pulse_o));
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader #(
    parameter int WORD_W      = 21,
    parameter int ADDR_W      = 2,
    parameter int NUM_LATCH   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int PD_LATCH    = 1,
    parameter int PD_BIT      = 0,
    localparam int PAYLOAD_W  = WORD_W - ADDR_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                ser_clk_i,
    input  logic                                ser_data_i,
    input  logic                                ser_load_i,
    input  logic                                chip_en_i,
    output logic [NUM_LATCH*PAYLOAD_W-1:0]      latches_o,
    output logic                                pwr_down_o,
    output logic                                load_pulse_o,
    output logic [ADDR_W-1:0]                   load_idx_o
);
    logic [3:0]                          pins_s;
    logic                                shift;
    logic                                fire;
    logic [WORD_W-1:0]                   word;
    logic [NUM_LATCH-1:0][PAYLOAD_W-1:0] bank;

    cwl_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({chip_en_i, ser_load_i, ser_clk_i, ser_data_i}),
        .q_o  (pins_s)
    );

    cwl_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s_i(pins_s[1]),
        .data_s_i(pins_s[0]),
        .shift_o (shift),
        .word_o  (word)
    );

    cwl_load_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .le_s_i(pins_s[2]),
        .fire_o(fire)
    );

    cwl_latch_bank #(.PAYLOAD_W(PAYLOAD_W), .ADDR_W(ADDR_W), .NUM_LATCH(NUM_LATCH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (fire),
        .word_i   (word),
        .latches_o(bank),
        .pulse_o  (load_pulse_o),
        .idx_o    (load_idx_o)
    );

    assign latches_o  = bank;
    assign pwr_down_o = ~pins_s[3] | bank[PD_LATCH][PD_BIT];

    // R8: update pulse lasts one cycle and names an existing register
    assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |=> !load_pulse_o);
    assert_pulse_idx_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse_o |-> (int'(load_idx_o) < NUM_LATCH));
    // R7: a shift in the load cycle does not disturb what is loaded
    assert_load_preshift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && shift && (int'(word[ADDR_W-1:0]) < NUM_LATCH)) |=>
        (bank[$past(word[ADDR_W-1:0])] == $past(word[WORD_W-1:ADDR_W])));
endmodule

// File: tb/cfg_word_loader_tb_top.sv
module cfg_word_loader_tb_top;
    localparam int PW = 19;
    localparam int NL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, chip_en = 1'b1;
    logic [NL*PW-1:0] latches;
    logic pwr_down, load_pulse;
    logic [1:0] load_idx;

    always #2 clk = ~clk;

    cfg_word_loader dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .ser_load_i(ser_load), .chip_en_i(chip_en), .latches_o(latches),
        .pwr_down_o(pwr_down), .load_pulse_o(load_pulse), .load_idx_o(load_idx)
    );

    int n_checks = 0, n_fail = 0;
    int seen_pulses = 0, exp_pulses = 0;
    logic [1:0] seen_idx = 2'd0, exp_idx = 2'd0;
    logic [20:0] m_sr = '0;
    logic [PW-1:0] exp_l [NL];
    bit done = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_pd();
        return !chip_en | exp_l[1][0];
    endfunction

    function automatic logic [PW-1:0] slice(input int k);
        return latches[k*PW +: PW];
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic model_load();
        if (m_sr[1:0] != 2'b11) begin
            exp_l[m_sr[1:0]] = m_sr[20:2];
            exp_pulses++;
            exp_idx = m_sr[1:0];
        end
    endtask

    // R8: new value visible in the pulse cycle, index matches
    always @(negedge clk) begin
        if (rst_n && load_pulse) begin
            seen_pulses++;
            seen_idx = load_idx;
            check("R8 value at pulse", {45'd0, slice(int'(load_idx))}, {45'd0, exp_l[load_idx]});
        end
    end

    task automatic send_bit(input logic b, input bit with_load);
        ser_data = b;
        wait_clk(4);
        ser_clk = 1'b1;
        if (with_load) begin
            ser_load = 1'b1;
            model_load();
        end
        m_sr = {m_sr[19:0], b};
        wait_clk(4);
        ser_clk = 1'b0;
        wait_clk(4);
    endtask

    task automatic send_word(input logic [20:0] w, input int extra);
        for (int i = 0; i < extra; i++) send_bit(1'($urandom), 0);
        for (int i = 20; i >= 0; i--) send_bit(w[i], 0);
    endtask

    task automatic strobe();
        ser_load = 1'b1;
        model_load();
        wait_clk(8);
        ser_load = 1'b0;
        wait_clk(8);
    endtask

    task automatic check_all(input string req);
        @(negedge clk);
        for (int k = 0; k < NL; k++)
            check({req, " register"}, {45'd0, slice(k)}, {45'd0, exp_l[k]});
        check({req, " R9 power-down"}, {63'd0, pwr_down}, {63'd0, exp_pd()});
        check({req, " R8 pulse count"}, 64'(seen_pulses), 64'(exp_pulses));
        if (exp_pulses > 0) check({req, " R8 index"}, {62'd0, seen_idx}, {62'd0, exp_idx});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait_clk(200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < NL; k++) exp_l[k] = '0;
        chip_en = 1'b1;
        wait_clk(5);
        @(negedge clk);
        // R1: reset state
        check("R1 pd in reset", {63'd0, pwr_down}, 64'd1);
        check("R1 latches in reset", {7'd0, latches}, 64'd0);
        check("R1 pulse in reset", {63'd0, load_pulse}, 64'd0);
        chip_en = 1'b0;
        rst_n = 1'b1;
        wait_clk(2);
        @(negedge clk);
        check("R1 pd after reset", {63'd0, pwr_down}, 64'd1);
        wait_clk(4);
        check_all("R1");

        // R2/R3: directed load of each register, MSB first
        send_word({19'h4_0001, 2'b00}, 0); strobe(); check_all("R3 reg0 R2 order");
        send_word({19'h2_AAAA, 2'b01}, 0); strobe(); check_all("R3 reg1 R5");
        send_word({19'h5_5554, 2'b10}, 0); strobe(); check_all("R3 reg2 R5");
        // R9: chip enable high, power-down follows reg1 bit 0
        chip_en = 1'b1; wait_clk(6); check_all("R9 ce high bit0 clear");
        send_word({19'h0_0001, 2'b01}, 0); strobe(); check_all("R9 ce high bit0 set");
        chip_en = 1'b0; wait_clk(6); check_all("R9 ce low");
        chip_en = 1'b1;
        // R4: reserved address
        send_word({19'h7_FFFF, 2'b11}, 0); strobe(); check_all("R4 reserved");
        // R6: strobe held high across a whole word, then lowered
        send_word({19'h1_2345, 2'b00}, 0);
        ser_load = 1'b1; model_load(); wait_clk(6);
        send_word({19'h6_789A, 2'b10}, 0);
        ser_load = 1'b0; wait_clk(10);
        check_all("R6 held strobe");
        strobe(); check_all("R6 next rise");
        // R10: over-length word
        send_word({19'h3_0F0F, 2'b01}, 7); strobe(); check_all("R10 extra bits");
        // R7: strobe and last clock together; pre-shift word addresses reg2
        send_word({19'h1_1111, 2'b10}, 0);
        send_bit(1'b1, 1);
        ser_load = 1'b0; wait_clk(10);
        check_all("R7 same cycle");

        // random words mixing addresses, extra bits, collisions, chip enable
        for (int n = 0; n < 50; n++) begin
            logic [20:0] w;
            w = 21'($urandom);
            chip_en = 1'($urandom);
            send_word(w, int'($urandom % 3));
            if (($urandom % 5) == 0) begin
                send_bit(1'($urandom), 1);
                ser_load = 1'b0; wait_clk(10);
            end else begin
                strobe();
            end
            check_all("R3 R4 R5 R7 random");
        end
        finish_run();
    end
endmodule